// File: doc/BRIEF.md
# Registered Two-Port Bus Transfer Block

This block moves 8-bit data, without inversion, between two bus ports called A and B. Each direction has its own holding register and its own source choice. The port on the far side can therefore take either the live value of the opposite bus or a value captured earlier. Each port is modelled as an external-input vector, a drive vector and a drive-enable flag. A pad ring outside the block turns these into a tri-state bus.

All controls are sampled on one system clock. The drive enables, the source choices and the driven data are all registered, so a change of source never produces an intermediate value on a driven port. Each capture strobe is passed through a synchronizer and edge-detected. On each detected rising edge, the block stores the value actually present on the matching bus: its own drive when the block is driving that port, and the external input otherwise.

When both directions are enabled and both pass live data, each port keeps driving the value it last held. Once outside drivers release, the two buses stay where they were.

Top module: `dual_port_xcvr`

## Requirements
- R1: `ab_en` is active high and controls `b_drv_en`. `ba_en_n` is active low and controls `a_drv_en`. Each flag follows its enable one clock later. With `ab_en`=0 and `ba_en_n`=1, neither port is driven.
- R2: On each path, a source choice of 0 passes the live resolved value of the opposite port and 1 passes that path's stored register. The driven vector is updated one clock after its inputs and is meaningful only while its drive flag is 1.
- R3: A rising edge on `a_strobe` (or `b_strobe`) loads the resolved A (or B) bus value into the A (or B) register. This happens at the third rising clock edge after the strobe rises, whatever the enables or source choices are.
- R4: The resolved value of a port is the block's own drive when that port's drive flag is 1, and the external input otherwise. With A driven from live B, strobing both ports loads the B data into both registers.
- R5: When both strobes are detected in the same cycle, each register takes the bus value from before that edge. With each port driven from stored data, this exchanges the two registers.
- R6: With both enables active and both source choices 0, each driven port keeps its own resolved value. On entry it takes what the bus held, and after that it holds regardless of external inputs.
- R7: The 8 bit lanes are independent and non-inverting for any data pattern.
- R8: A synchronous active-high reset clears both registers, both drive vectors, both drive flags and the strobe synchronizers to zero.
- R9: A strobe held high captures only once. While it stays high, the register keeps its value even if the bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value seen on bus A from outside |
| a_drv | output | 8 | Value the block drives onto bus A |
| a_drv_en | output | 1 | Block drives bus A |
| b_in | input | 8 | Value seen on bus B from outside |
| b_drv | output | 8 | Value the block drives onto bus B |
| b_drv_en | output | 1 | Block drives bus B |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ba_en_n | input | 1 | B-to-A drive enable, active low |
| ab_src | input | 1 | B-side source: 0 live A, 1 A register |
| ba_src | input | 1 | A-side source: 0 live B, 1 B register |
| a_strobe | input | 1 | Capture strobe for the A register |
| b_strobe | input | 1 | Capture strobe for the B register |

## Verification
The hardest case to reach is a simultaneous capture on both ports while each port is driven from the other path's register. It requires that both registers were first loaded with distinct values through separate, correctly delayed strobes, and then that both enables are held and both strobes rise in the same clock. A directed sequence builds exactly that state and then reads both registers back through the stored-source path. The self-holding mode is entered both from a directed setup and from random control combinations. Meanwhile a cycle model in the bench tracks drive, capture and synchronizer delay.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_strobe_sync.sv
module xcvr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic pulse
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LEN-2:0], strobe};
  end

  assign pulse = chain[STAGES-1] & ~chain[STAGES];

  // R9: one detected edge gives a single-cycle pulse
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_val,
  input  logic         en,
  input  src_sel_e     sel,
  input  logic         hold,
  input  logic [W-1:0] own_val,
  output logic [W-1:0] drv,
  output logic         drv_en,
  output logic [W-1:0] stored
);
  logic [W-1:0] next_drv;

  function automatic logic [W-1:0] pick(input src_sel_e s, input logic hl,
                                        input logic [W-1:0] live,
                                        input logic [W-1:0] reg_v,
                                        input logic [W-1:0] keep);
    if (hl)                 return keep;
    else if (s == SRC_LIVE) return live;
    else                    return reg_v;
  endfunction

  assign next_drv = pick(sel, hold, cap_val, stored, own_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= '0;
      drv    <= '0;
      drv_en <= 1'b0;
    end else begin
      if (cap) stored <= cap_val;
      drv    <= next_drv;
      drv_en <= en;
    end
  end

  p_enable_follow_r1: assert property (@(posedge clk) disable iff (rst)
    en |=> drv_en);
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    cap |=> stored == $past(cap_val));
  p_stored_src_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_STORED && !hold) |=> drv == $past(stored));
  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (hold && drv_en) |=> drv == $past(drv));
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (stored == '0 && !drv_en));
endmodule

// File: rtl/dual_port_xcvr.sv
module dual_port_xcvr
  import xcvr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_drv,
  output logic         a_drv_en,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_drv,
  output logic         b_drv_en,
  input  logic         ab_en,
  input  logic         ba_en_n,
  input  logic         ab_src,
  input  logic         ba_src,
  input  logic         a_strobe,
  input  logic         b_strobe
);
  function automatic logic [W-1:0] resolve(input logic oe,
                                           input logic [W-1:0] own,
                                           input logic [W-1:0] ext);
    return oe ? own : ext;
  endfunction

  logic [W-1:0] a_res, b_res, a_reg, b_reg;
  logic         a_cap, b_cap, hold, ba_en;

  assign a_res = resolve(a_drv_en, a_drv, a_in);
  assign b_res = resolve(b_drv_en, b_drv, b_in);
  assign ba_en = ~ba_en_n;
  assign hold  = ab_en & ba_en & ~ab_src & ~ba_src;

  xcvr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .strobe(a_strobe), .pulse(a_cap));
  xcvr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .strobe(b_strobe), .pulse(b_cap));

  xcvr_path #(.W(W)) u_path_ab (
    .clk(clk), .rst(rst), .cap(a_cap), .cap_val(a_res),
    .en(ab_en), .sel(src_sel_e'(ab_src)), .hold(hold), .own_val(b_res),
    .drv(b_drv), .drv_en(b_drv_en), .stored(a_reg));

  xcvr_path #(.W(W)) u_path_ba (
    .clk(clk), .rst(rst), .cap(b_cap), .cap_val(b_res),
    .en(ba_en), .sel(src_sel_e'(ba_src)), .hold(hold), .own_val(a_res),
    .drv(a_drv), .drv_en(a_drv_en), .stored(b_reg));

  p_isolate_r1: assert property (@(posedge clk) disable iff (rst)
    (!ab_en && ba_en_n) |=> (!a_drv_en && !b_drv_en));
  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
    (a_cap && b_cap && a_drv_en && b_drv_en)
      |=> (a_reg == $past(a_drv) && b_reg == $past(b_drv)));
  p_live_r4: assert property (@(posedge clk) disable iff (rst)
    (ba_en && !ba_src && !hold) |=> a_drv == $past(b_res));
endmodule

// File: tb/dual_port_xcvr_tb_top.sv
module dual_port_xcvr_tb_top;
  localparam int CLK_NS = 10;
  localparam int W = 8;

  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = 0, b_in = 0, a_drv, b_drv;
  logic a_drv_en, b_drv_en;
  logic ab_en = 0, ba_en_n = 1, ab_src = 0, ba_src = 0, a_strobe = 0, b_strobe = 0;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_port_xcvr dut_i (.clk(clk), .rst(rst), .a_in(a_in), .a_drv(a_drv),
    .a_drv_en(a_drv_en), .b_in(b_in), .b_drv(b_drv), .b_drv_en(b_drv_en),
    .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_src(ab_src), .ba_src(ba_src),
    .a_strobe(a_strobe), .b_strobe(b_strobe));

  // bench model of the requirements
  logic [W-1:0] m_ad = 0, m_bd = 0, m_ra = 0, m_rb = 0;
  logic m_ade = 0, m_bde = 0;
  logic [2:0] m_sa = 0, m_sb = 0;

  function automatic logic [W-1:0] bus_val(input logic oe, input logic [W-1:0] d,
                                           input logic [W-1:0] ext);
    return oe ? d : ext;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] ra, rb;
    logic keep;
    ra = bus_val(m_ade, m_ad, a_in);
    rb = bus_val(m_bde, m_bd, b_in);
    keep = ab_en && !ba_en_n && !ab_src && !ba_src;
    if (rst) begin
      m_ad <= 0; m_bd <= 0; m_ra <= 0; m_rb <= 0;
      m_ade <= 0; m_bde <= 0; m_sa <= 0; m_sb <= 0;
    end else begin
      m_bde <= ab_en;
      m_ade <= !ba_en_n;
      m_bd  <= keep ? rb : (ab_src ? m_ra : ra);
      m_ad  <= keep ? ra : (ba_src ? m_rb : rb);
      m_sa  <= {m_sa[1:0], a_strobe};
      m_sb  <= {m_sb[1:0], b_strobe};
      if (m_sa[1] && !m_sa[2]) m_ra <= ra;
      if (m_sb[1] && !m_sb[2]) m_rb <= rb;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic chk_model(input string tag);
    n_run++;
    if (a_drv_en !== m_ade || b_drv_en !== m_bde ||
        (m_ade && a_drv !== m_ad) || (m_bde && b_drv !== m_bd)) begin
      n_fail++;
      $display("FAIL %s: act a=%h/%b b=%h/%b exp a=%h/%b b=%h/%b", tag,
               a_drv, a_drv_en, b_drv, b_drv_en, m_ad, m_ade, m_bd, m_bde);
    end
  endtask

  task automatic chk_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // read both registers back through the stored-source paths
  task automatic read_regs(input string tag, input logic [W-1:0] ea, input logic [W-1:0] eb);
    ab_en = 1; ba_en_n = 0; ab_src = 1; ba_src = 1;
    tick();
    chk_val({tag, " A reg"}, b_drv, ea);
    chk_val({tag, " B reg"}, a_drv, eb);
  endtask

  task automatic pulse_strobes(input logic sa, input logic sb);
    a_strobe = sa; b_strobe = sb;
    tick(3);
    a_strobe = 0; b_strobe = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(2);
    // R8: reset state
    chk_val("R8 a_drv_en", {7'd0, a_drv_en}, 8'd0);
    chk_val("R8 b_drv_en", {7'd0, b_drv_en}, 8'd0);
    rst = 0;
    read_regs("R8", 8'h00, 8'h00);

    // R1: isolation
    ab_en = 0; ba_en_n = 1; a_in = 8'hFF; b_in = 8'hFF;
    tick();
    chk_val("R1 isolation", {6'd0, a_drv_en, b_drv_en}, 8'd0);
    chk_model("R1 model");

    // R2 R7: live A to B
    ab_en = 1; ab_src = 0; a_in = 8'h5A;
    tick();
    chk_val("R2 live A->B", b_drv, 8'h5A);
    chk_val("R1 b_drv_en", {7'd0, b_drv_en}, 8'd1);

    // R3: capture A, then change bus and read stored
    ab_en = 0; a_in = 8'h3C;
    pulse_strobes(1, 0);
    a_in = 8'h99;
    read_regs("R3", 8'h3C, 8'h00);

    // R9: strobe held high captures once
    ab_en = 0; ba_en_n = 1; a_in = 8'h71; a_strobe = 1;
    tick(3);
    a_in = 8'hE4;
    tick(5);
    a_strobe = 0;
    read_regs("R9", 8'h71, 8'h00);

    // R4: A driven from live B, strobe both
    ab_en = 0; ba_en_n = 0; ba_src = 0; a_in = 8'h00; b_in = 8'hC3;
    tick();
    pulse_strobes(1, 1);
    read_regs("R4", 8'hC3, 8'hC3);

    // R5: load distinct values then swap while both drive stored data
    ab_en = 0; ba_en_n = 1; a_in = 8'hA1; b_in = 8'h1B;
    tick();
    pulse_strobes(1, 1);
    read_regs("R5 setup", 8'hA1, 8'h1B);
    pulse_strobes(1, 1);
    read_regs("R5 swap", 8'h1B, 8'hA1);

    // R6: both live enabled holds each bus
    ab_en = 0; ba_en_n = 1; a_in = 8'h11; b_in = 8'h22;
    tick();
    ab_en = 1; ba_en_n = 0; ab_src = 0; ba_src = 0;
    tick();
    chk_val("R6 entry A", a_drv, 8'h11);
    chk_val("R6 entry B", b_drv, 8'h22);
    a_in = 8'hEE; b_in = 8'hDD;
    tick(3);
    chk_val("R6 hold A", a_drv, 8'h11);
    chk_val("R6 hold B", b_drv, 8'h22);
    chk_model("R6 model");

    // R2 R3 R7: random controls and data against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      a_in = r[7:0]; b_in = r[15:8];
      ab_en = r[16]; ba_en_n = r[17]; ab_src = r[18]; ba_src = r[19];
      a_strobe = (r[23:20] == 0) ? ~a_strobe : a_strobe;
      b_strobe = (r[27:24] == 0) ? ~b_strobe : b_strobe;
      tick();
      chk_model("R7 random");
    end

    // R8: reset mid-run
    rst = 1;
    tick();
    rst = 0;
    chk_model("R8 re-reset");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule